// File: doc/BRIEF.md
# Pulse-Distance Infrared Frame Encoder

This block turns a key press into the on/off envelope for an infrared remote-control transmitter. The envelope gates an external carrier generator: when it is high the carrier is sent, when it is low the output is dark. Bits are coded by distance. Every bit begins with a short mark of fixed length, and the length of the dark space that follows tells a zero from a one.

When `key_i` rises from idle, the block captures the address and command bytes. It then sends a full frame: a long leader mark, a leader space, 32 payload bits and a closing stop mark. For as long as the key stays down, it sends a short repeat code on a fixed 108 ms grid, counted from the start of the first frame. Releasing the key never cuts a frame or a repeat code short. The block goes idle after the stop mark that is under way.

All durations are built from a 5 µs timing step. The parameter `CLK_PER_STEP` gives the number of clock cycles in one step, so a bench can shrink time by setting it to 1.

Top module: `ir_frame_enc`

## Requirements
- R1: A full frame opens with a mark of 1800 steps (9 ms), followed by a space of 900 steps (4.5 ms). The mark begins in the clock cycle after `key_i` is seen high while idle.
- R2: Each payload bit is a mark of 112 steps followed by a space. The space is 113 steps for a 0 (1.125 ms bit) and 338 steps for a 1 (2.25 ms bit).
- R3: The 32 payload bits are sent in this order: address byte, second byte, command byte, bitwise inverse of the command byte. Each byte goes out least significant bit first.
- R4: With `EXT_ADDR`=0 (the default), the second byte is the bitwise inverse of `custom_i`, and `custom_ext_i` has no effect on the envelope. With `EXT_ADDR`=1, the second byte is `custom_ext_i`.
- R5: The last payload bit is followed by one stop mark of 112 steps. The envelope is low after it.
- R6: If the key is still held at the end of the frame period, a repeat code starts exactly 21600 steps (108 ms) after the previous frame start. It is a 1800-step mark, a 450-step space and a 112-step stop mark, and repeats follow on the same grid.
- R7: Releasing the key never shortens a mark or space in progress. After the stop mark of the current frame or repeat code, no further mark is sent until the key is pressed again.
- R8: `busy_o` is high from the first cycle of a leader mark to the last cycle of the stop mark. It is low when idle and during the dark gap between frames.
- R9: Input bytes are captured only at the start of a full frame. Changes to them during a frame or during repeats do not alter the envelope, and a new press sends the bytes present at that press.
- R10: During and directly after reset, `env_o` and `busy_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_i | input | 1 | Key held (level) |
| custom_i | input | 8 | Address byte |
| custom_ext_i | input | 8 | Second address byte, used only when `EXT_ADDR`=1 |
| data_i | input | 8 | Command byte |
| env_o | output | 1 | Carrier envelope, high = carrier on |
| busy_o | output | 1 | Frame or repeat code being sent |

## Verification
The hardest case to reach from the ports is a key release that falls inside a repeat code, after the key has been held across more than one 108 ms grid boundary. That case checks two things at once: the repeat grid stays aligned to the first frame start, and the release neither truncates the repeat nor starts another one.

The stimulus holds the key for two full periods plus a few hundred cycles, so the release lands inside the second repeat's leader mark. It also changes the command byte early in the first frame. A later press with the key released in the middle of the payload covers release during a full frame. A third press changes the second-address input while the key is held, to show that input has no effect.

// File: rtl/ir_enc_pkg.sv
package ir_enc_pkg;
  // timing step is 5 us; all counts below are in steps
  localparam int unsigned LEAD_MARK_STEPS  = 1800;
  localparam int unsigned LEAD_SPACE_STEPS = 900;
  localparam int unsigned BIT_MARK_STEPS   = 112;
  localparam int unsigned ZERO_SPACE_STEPS = 113;
  localparam int unsigned ONE_SPACE_STEPS  = 338;
  localparam int unsigned REP_SPACE_STEPS  = 450;
  localparam int unsigned STOP_STEPS       = 112;
  localparam int unsigned FRAME_STEPS      = 21600;
  localparam int unsigned PAYLOAD_BITS     = 32;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LEAD_MARK,
    ST_LEAD_SPACE,
    ST_BIT_MARK,
    ST_BIT_SPACE,
    ST_STOP,
    ST_GAP,
    ST_REP_MARK,
    ST_REP_SPACE
  } state_e;
endpackage

// File: rtl/ir_enc_seg_timer.sv
module ir_enc_seg_timer #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] len_i,    // segment length minus one
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= len_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/ir_enc_frame_grid.sv
module ir_enc_frame_grid #(
  parameter int unsigned PERIOD = 21600,
  localparam int unsigned W     = $clog2(PERIOD)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic wrap_o
);
  localparam logic [W-1:0] LAST = W'(PERIOD - 1);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (restart_i)       cnt_q <= '0;
    else if (cnt_q == LAST)   cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign wrap_o = (cnt_q == LAST);
endmodule

// File: rtl/ir_enc_payload.sv
module ir_enc_payload #(
  parameter bit          EXT_ADDR = 1'b0,
  parameter int unsigned NBITS    = 32,
  localparam int unsigned IW      = $clog2(NBITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             latch_i,
  input  logic             adv_i,
  input  logic [7:0]       custom_i,
  input  logic [7:0]       custom_ext_i,
  input  logic [7:0]       data_i,
  output logic [NBITS-1:0] frame_o,
  output logic [IW-1:0]    idx_o
);
  logic [7:0] second_w;

  generate
    if (EXT_ADDR) begin : g_ext
      assign second_w = custom_ext_i;
    end else begin : g_inv
      logic [7:0] unused_ext;
      assign unused_ext = custom_ext_i;
      assign second_w   = ~custom_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_o <= '0;
      idx_o   <= '0;
    end else if (latch_i) begin
      // bit 0 goes out first
      frame_o <= NBITS'({~data_i, data_i, second_w, custom_i});
      idx_o   <= '0;
    end else if (adv_i) begin
      idx_o   <= idx_o + 1'b1;
    end
  end
endmodule

// File: rtl/ir_frame_enc.sv
module ir_frame_enc
  import ir_enc_pkg::*;
#(
  parameter int unsigned CLK_PER_STEP = 40,
  parameter bit          EXT_ADDR     = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       key_i,
  input  logic [7:0] custom_i,
  input  logic [7:0] custom_ext_i,
  input  logic [7:0] data_i,
  output logic       env_o,
  output logic       busy_o
);
  localparam int unsigned FRAME_CLKS = FRAME_STEPS * CLK_PER_STEP;
  localparam int unsigned CW         = $clog2(FRAME_CLKS);
  localparam int unsigned IW         = $clog2(PAYLOAD_BITS);

  localparam logic [CW-1:0] L_LEAD_M = CW'(LEAD_MARK_STEPS  * CLK_PER_STEP - 1);
  localparam logic [CW-1:0] L_LEAD_S = CW'(LEAD_SPACE_STEPS * CLK_PER_STEP - 1);
  localparam logic [CW-1:0] L_BIT_M  = CW'(BIT_MARK_STEPS   * CLK_PER_STEP - 1);
  localparam logic [CW-1:0] L_ZERO   = CW'(ZERO_SPACE_STEPS * CLK_PER_STEP - 1);
  localparam logic [CW-1:0] L_ONE    = CW'(ONE_SPACE_STEPS  * CLK_PER_STEP - 1);
  localparam logic [CW-1:0] L_REP_S  = CW'(REP_SPACE_STEPS  * CLK_PER_STEP - 1);
  localparam logic [CW-1:0] L_STOP   = CW'(STOP_STEPS       * CLK_PER_STEP - 1);
  localparam logic [IW-1:0] LAST_IDX = IW'(PAYLOAD_BITS - 1);

  state_e                  state_q, state_d;
  logic [CW-1:0]           len_d;
  logic                    seg_done, grid_wrap, latch, adv;
  logic [PAYLOAD_BITS-1:0] frame_w;
  logic [IW-1:0]           idx_w;

  ir_enc_seg_timer #(.W(CW)) u_seg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (state_d != state_q),
    .len_i  (len_d),
    .done_o (seg_done)
  );

  ir_enc_frame_grid #(.PERIOD(FRAME_CLKS)) u_grid (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (latch),
    .wrap_o    (grid_wrap)
  );

  ir_enc_payload #(.EXT_ADDR(EXT_ADDR), .NBITS(PAYLOAD_BITS)) u_pay (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .latch_i      (latch),
    .adv_i        (adv),
    .custom_i     (custom_i),
    .custom_ext_i (custom_ext_i),
    .data_i       (data_i),
    .frame_o      (frame_w),
    .idx_o        (idx_w)
  );

  always_comb begin
    state_d = state_q;
    len_d   = '0;
    latch   = 1'b0;
    adv     = 1'b0;
    unique case (state_q)
      ST_IDLE: if (key_i) begin
        state_d = ST_LEAD_MARK; len_d = L_LEAD_M; latch = 1'b1;
      end
      ST_LEAD_MARK: if (seg_done) begin
        state_d = ST_LEAD_SPACE; len_d = L_LEAD_S;
      end
      ST_LEAD_SPACE: if (seg_done) begin
        state_d = ST_BIT_MARK; len_d = L_BIT_M;
      end
      ST_BIT_MARK: if (seg_done) begin
        state_d = ST_BIT_SPACE; len_d = frame_w[idx_w] ? L_ONE : L_ZERO;
      end
      ST_BIT_SPACE: if (seg_done) begin
        adv = 1'b1;
        if (idx_w == LAST_IDX) begin
          state_d = ST_STOP; len_d = L_STOP;
        end else begin
          state_d = ST_BIT_MARK; len_d = L_BIT_M;
        end
      end
      ST_STOP: if (seg_done) state_d = key_i ? ST_GAP : ST_IDLE;
      ST_GAP: begin
        if (!key_i) state_d = ST_IDLE;
        else if (grid_wrap) begin
          state_d = ST_REP_MARK; len_d = L_LEAD_M;
        end
      end
      ST_REP_MARK: if (seg_done) begin
        state_d = ST_REP_SPACE; len_d = L_REP_S;
      end
      ST_REP_SPACE: if (seg_done) begin
        state_d = ST_STOP; len_d = L_STOP;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign env_o  = (state_q == ST_LEAD_MARK) || (state_q == ST_BIT_MARK) ||
                  (state_q == ST_STOP)      || (state_q == ST_REP_MARK);
  assign busy_o = (state_q != ST_IDLE) && (state_q != ST_GAP);
endmodule

// File: rtl/ir_frame_enc_checker.sv
module ir_frame_enc_checker
  import ir_enc_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        key_i,
  input logic        env_o,
  input logic        busy_o,
  input state_e      state_q,
  input logic        seg_done,
  input logic [31:0] frame_w
);
  a_r8_env_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    env_o |-> busy_o);

  a_r1_lead_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && key_i) |=> (env_o && busy_o));

  a_r9_latch_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> $stable(frame_w));

  a_r5_stop_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP && seg_done) |=> !env_o);

  a_r7_mark_whole: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (env_o && !seg_done) |=> env_o);
endmodule

bind ir_frame_enc ir_frame_enc_checker u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .key_i    (key_i),
  .env_o    (env_o),
  .busy_o   (busy_o),
  .state_q  (state_q),
  .seg_done (seg_done),
  .frame_w  (frame_w)
);

// File: tb/ir_frame_enc_tb_top.sv
module ir_frame_enc_tb_top;
  // one step per clock
  localparam int LM = 1800, LS = 900, BM = 112, S0 = 113, S1 = 338;
  localparam int RS = 450, SP = 112, FR = 21600;

  typedef struct {
    bit    lvl;
    int    len;    // 0 = open-ended
    bit    busy;
    string tag;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0, key = 1'b0;
  logic [7:0] cust = '0, cext = '0, dat = '0;
  logic env, busy;
  item_t q[$];
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ir_frame_enc #(.CLK_PER_STEP(1), .EXT_ADDR(1'b0)) dut_i (
    .clk_i (clk), .rst_ni (rst_n), .key_i (key),
    .custom_i (cust), .custom_ext_i (cext), .data_i (dat),
    .env_o (env), .busy_o (busy)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push(input bit l, input int n, input bit b, input string t);
    item_t it;
    it.lvl = l; it.len = n; it.busy = b; it.tag = t;
    q.push_back(it);
  endtask

  // pushes a full frame and returns its body length
  task automatic push_frame(input logic [7:0] c, input logic [7:0] d, output int body);
    logic [31:0] p;
    p = {~d, d, ~c, c};
    push(1'b1, LM, 1'b1, "R1 lead mark");
    push(1'b0, LS, 1'b1, "R1 lead space");
    body = LM + LS + SP;
    for (int i = 0; i < 32; i++) begin
      push(1'b1, BM, 1'b1, "R2 bit mark");
      if (i < 8)       push(1'b0, p[i] ? S1 : S0, 1'b1, "R2 R3 address bit");
      else if (i < 16) push(1'b0, p[i] ? S1 : S0, 1'b1, "R3 R4 second byte bit");
      else             push(1'b0, p[i] ? S1 : S0, 1'b1, "R3 R9 command bit");
      body += BM + (p[i] ? S1 : S0);
    end
    push(1'b1, SP, 1'b1, "R5 stop mark");
  endtask

  task automatic push_rep();
    push(1'b1, LM, 1'b1, "R6 repeat mark");
    push(1'b0, RS, 1'b1, "R6 repeat space");
    push(1'b1, SP, 1'b1, "R6 repeat stop");
  endtask

  // monitor: run-length compare of the envelope
  initial begin
    item_t cur;
    bit prev;
    int run;
    @(posedge rst_n);
    @(negedge clk);
    cur = q.pop_front();
    check(env == cur.lvl, {cur.tag, " level"}, env, cur.lvl);
    check(busy == cur.busy, {cur.tag, " R8 busy"}, busy, cur.busy);
    prev = env; run = 1;
    forever begin
      @(negedge clk);
      if (env !== prev) begin
        if (cur.len != 0) check(run == cur.len, {cur.tag, " length"}, run, cur.len);
        if (q.size() == 0) begin
          check(1'b0, "R7 unexpected envelope edge", env, prev);
          cur.lvl = env; cur.len = 0; cur.busy = busy; cur.tag = "R7 extra";
        end else begin
          cur = q.pop_front();
          check(env == cur.lvl, {cur.tag, " level"}, env, cur.lvl);
          check(busy == cur.busy, {cur.tag, " R8 busy"}, busy, cur.busy);
        end
        prev = env; run = 1;
      end else run++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int b;
    push(1'b0, 0, 1'b0, "R10 reset idle");
    repeat (3) @(negedge clk);
    check(env == 1'b0, "R10 env in reset", env, 0);
    check(busy == 1'b0, "R10 busy in reset", busy, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // held across two grid boundaries; release inside second repeat mark
    push_frame(8'hA5, 8'h1E, b);
    push(1'b0, FR - b, 1'b0, "R6 R8 gap after frame");
    push_rep();
    push(1'b0, FR - (LM + RS + SP), 1'b0, "R6 gap after repeat");
    push_rep();
    push(1'b0, 0, 1'b0, "R7 idle after release");
    cust = 8'hA5; cext = 8'h3C; dat = 8'h1E; key = 1'b1;
    repeat (100) @(negedge clk);
    dat = 8'h77; cust = 8'h00;            // R9: must not alter frame
    repeat (2 * FR + 400) @(negedge clk);
    key = 1'b0;                           // R7: inside repeat mark
    repeat (3500) @(negedge clk);

    // release in the middle of a full frame
    push_frame(8'hFF, 8'h00, b);
    push(1'b0, 0, 1'b0, "R7 idle after cut press");
    cust = 8'hFF; dat = 8'h00; key = 1'b1;
    repeat (5000) @(negedge clk);
    key = 1'b0;
    repeat (15000) @(negedge clk);

    // second-address input toggles while held: no effect
    push_frame(8'h01, 8'hC3, b);
    push(1'b0, FR - b, 1'b0, "R4 gap");
    push_rep();
    push(1'b0, 0, 1'b0, "R7 final idle");
    cust = 8'h01; dat = 8'hC3; cext = 8'h00; key = 1'b1;
    repeat (300) @(negedge clk);
    cext = 8'hFE;
    repeat (3000) @(negedge clk);
    cext = 8'h55;
    repeat (FR + 1000 - 3300) @(negedge clk);
    key = 1'b0;
    repeat (3000) @(negedge clk);

    check(q.size() == 0, "R7 R6 pending items", q.size(), 0);
    check(busy == 1'b0, "R8 busy at end", busy, 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule